// File: doc/BRIEF.md
# Supply Pulse Programming Decoder

This block sits behind an analog front end that watches a sensor's supply pin. The front end sorts the supply voltage into four bands and hands over a 2-bit level code every clock: 0 for zero, 1 for low, 2 for mid and 3 for high. The block reads the pulses in that stream and uses them to set the bits of a 6-bit calibration code. Each bit can be set for trial only or burned in for good, and a final lock ends all programming.

A programming sequence has three parts. First comes a keying pattern: one short high pulse, at least a minimum number of mid pulses, then one more high pulse. Next comes a run of mid pulses whose count is the target bit address. Last comes a high pulse that closes the address. If that high pulse is short, it sets the addressed bit in the volatile register. If it is long, it also blows that bit's fuse and sends a one-cycle strobe to the fuse circuitry. Letting the supply fall to zero clears the volatile bits, while holding it at the low level keeps them between sequences. The code the block presents is the volatile register ORed with the fuse register. Address 65 is the lock, and blowing it stops any later keying pattern from being accepted.

Top module: `spp_decoder`

## Requirements
- R1: Right after reset, the calibration code is 0, the lock is clear and no blow strobe is active.
- R2: Addressing is enabled only by this pattern: a high pulse shorter than LONG_CYC samples, then at least KEY_MIN (7) mid pulses, then a high pulse of any length. With fewer mid pulses, or a long opening high pulse, the address pulses that follow have no effect.
- R3: Once addressing is enabled, the address n is the number of mid pulses that follow. A high pulse shorter than LONG_CYC samples then sets code bit n-1 (weight 2^(n-1)) for n from 1 to 6. The code changes one clock after the first sample where the level has left high.
- R4: A closing high pulse of at least LONG_CYC samples sets the bit and blows its fuse. blow_o then shows bit n-1 alone (one-hot) for exactly one clock, in the same cycle that the code bit first shows.
- R5: A zero-level sample clears every volatile bit and aborts any sequence in progress. Fused bits stay at 1 for good, and code_o always equals the volatile bits ORed with the fused bits.
- R6: While the supply stays at the low level, sequences add to each other. Addresses 3 and 1 together give code 5.
- R7: Address 0, addresses 7 to 64, addresses above 65, and a short close on address 65 change nothing and raise no strobe.
- R8: A long close on address 65 sets lock_o for good and strobes blow_o bit 6. From then on, keying patterns are ignored and no further bit can be set.
- R9: Each closing high pulse ends addressing mode. Mid and high pulses sent after it without a fresh keying pattern set nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all state, fuses included |
| lvl_i | input | 2 | Quantized supply level: 0 zero, 1 low, 2 mid, 3 high |
| code_o | output | CODE_W (6) | Effective calibration code, volatile OR fused |
| lock_o | output | 1 | Device lock fuse state |
| blow_o | output | CODE_W+1 (7) | One-cycle fuse-blow strobes; bit CODE_W is the lock |

## Verification
The bench drives keying patterns that are one mid pulse short and ones that open with a long high pulse. A decoder that counts the threshold wrong, or does not check the length of the opening pulse, would then set bits it should refuse. It sends address pulses with no fresh keying pattern after a delimiter, to catch a decoder that stays in addressing mode. It also sends address 0, out-of-range addresses and a short close on the lock address, which a loose address compare would turn into writes or strobes. Finally it drops the supply to zero after a fuse blow and tries to program after the lock. A design that cleared fuses together with the volatile bits, or kept accepting keying patterns once locked, would show a wrong code at that point.

// File: rtl/spp_pkg.sv
package spp_pkg;

   typedef enum logic [1:0] {
      LV_ZERO = 2'd0,
      LV_LOW  = 2'd1,
      LV_MID  = 2'd2,
      LV_HIGH = 2'd3
   } lvl_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_KEY  = 2'd1,
      ST_ADDR = 2'd2
   } seq_st_e;

endpackage

// File: rtl/spp_pulse_meter.sv
module spp_pulse_meter
   import spp_pkg::*;
#(
   parameter int LONG_CYC = 16
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] lvl_i,
   output logic       zero_o,
   output logic       mid_end_o,
   output logic       hi_end_o,
   output logic       hi_long_o
);
   localparam int HW = $clog2(LONG_CYC + 1);
   localparam logic [HW-1:0] HMAX = HW'(LONG_CYC);

   lvl_e          cur;
   lvl_e          prev_q;
   logic [HW-1:0] hrun_q;

   assign cur = lvl_e'(lvl_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= LV_ZERO;
         hrun_q <= '0;
      end else begin
         prev_q <= cur;
         if (cur != LV_HIGH)
            hrun_q <= '0;
         else if (prev_q != LV_HIGH)
            hrun_q <= HW'(1);
         else if (hrun_q != HMAX)
            hrun_q <= hrun_q + HW'(1);
      end
   end

   assign zero_o    = (cur == LV_ZERO);
   assign mid_end_o = (prev_q == LV_MID)  && (cur != LV_MID);
   assign hi_end_o  = (prev_q == LV_HIGH) && (cur != LV_HIGH);
   assign hi_long_o = (hrun_q >= HMAX);

endmodule

// File: rtl/spp_seq_fsm.sv
module spp_seq_fsm
   import spp_pkg::*;
#(
   parameter int KEY_MIN   = 7,
   parameter int LOCK_ADDR = 65,
   localparam int AW = $clog2(LOCK_ADDR + 2)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          zero_i,
   input  logic          mid_end_i,
   input  logic          hi_end_i,
   input  logic          hi_long_i,
   input  logic          locked_i,
   output logic          wr_v_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          wr_long_o
);
   localparam int KW = $clog2(KEY_MIN + 1);
   localparam logic [KW-1:0] KMAX = KW'(KEY_MIN);

   seq_st_e       st_q;
   logic [KW-1:0] kcnt_q;
   logic [AW-1:0] acnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         kcnt_q <= '0;
         acnt_q <= '0;
      end else if (zero_i) begin
         st_q   <= ST_IDLE;
         kcnt_q <= '0;
         acnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (hi_end_i && !hi_long_i && !locked_i) begin
                  st_q   <= ST_KEY;
                  kcnt_q <= '0;
               end
            end
            ST_KEY: begin
               if (mid_end_i) begin
                  if (kcnt_q != KMAX) kcnt_q <= kcnt_q + KW'(1);
               end else if (hi_end_i) begin
                  if (kcnt_q == KMAX) begin
                     st_q   <= ST_ADDR;
                     acnt_q <= '0;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            ST_ADDR: begin
               if (mid_end_i) begin
                  if (acnt_q != {AW{1'b1}}) acnt_q <= acnt_q + AW'(1);
               end else if (hi_end_i) begin
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_v_o    = (st_q == ST_ADDR) && hi_end_i && !zero_i;
   assign wr_addr_o = acnt_q;
   assign wr_long_o = hi_long_i;

endmodule

// File: rtl/spp_bit_store.sv
module spp_bit_store #(
   parameter int CODE_W    = 6,
   parameter int LOCK_ADDR = 65,
   localparam int AW = $clog2(LOCK_ADDR + 2)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            zero_i,
   input  logic            wr_v_i,
   input  logic [AW-1:0]   wr_addr_i,
   input  logic            wr_long_i,
   output logic [CODE_W-1:0] code_o,
   output logic [CODE_W:0] fuse_o,
   output logic [CODE_W:0] blow_o
);
   logic [CODE_W-1:0] vol_q;
   logic [CODE_W:0]   fuse_q;
   logic [CODE_W:0]   blow_q;

   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      logic hit;
      assign hit = wr_v_i && (wr_addr_i == AW'(i + 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vol_q[i]  <= 1'b0;
            fuse_q[i] <= 1'b0;
            blow_q[i] <= 1'b0;
         end else begin
            if (zero_i)   vol_q[i] <= 1'b0;
            else if (hit) vol_q[i] <= 1'b1;
            if (hit && wr_long_i) fuse_q[i] <= 1'b1;
            blow_q[i] <= hit && wr_long_i;
         end
      end
   end

   logic lock_hit;
   assign lock_hit = wr_v_i && wr_long_i && (wr_addr_i == AW'(LOCK_ADDR));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fuse_q[CODE_W] <= 1'b0;
         blow_q[CODE_W] <= 1'b0;
      end else begin
         if (lock_hit) fuse_q[CODE_W] <= 1'b1;
         blow_q[CODE_W] <= lock_hit;
      end
   end

   assign code_o = vol_q | fuse_q[CODE_W-1:0];
   assign fuse_o = fuse_q;
   assign blow_o = blow_q;

endmodule

// File: rtl/spp_decoder.sv
module spp_decoder #(
   parameter int CODE_W    = 6,
   parameter int KEY_MIN   = 7,
   parameter int LONG_CYC  = 16,
   parameter int LOCK_ADDR = 65
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        lvl_i,
   output logic [CODE_W-1:0] code_o,
   output logic              lock_o,
   output logic [CODE_W:0]   blow_o
);
   localparam int AW = $clog2(LOCK_ADDR + 2);

   if (CODE_W < 1) begin : g_bad_code_w
      $error("CODE_W must be at least 1");
   end
   if (LOCK_ADDR <= CODE_W) begin : g_bad_lock
      $error("LOCK_ADDR must lie above the code bit addresses");
   end
   if (KEY_MIN < 1) begin : g_bad_key
      $error("KEY_MIN must be at least 1");
   end
   if (LONG_CYC < 2) begin : g_bad_long
      $error("LONG_CYC must be at least 2");
   end

   logic          zero, mid_end, hi_end, hi_long;
   logic          wr_v, wr_long;
   logic [AW-1:0] wr_addr;
   logic [CODE_W:0] fuse_q;

   spp_pulse_meter #(.LONG_CYC(LONG_CYC)) meter_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_i),
      .zero_o    (zero),
      .mid_end_o (mid_end),
      .hi_end_o  (hi_end),
      .hi_long_o (hi_long)
   );

   spp_seq_fsm #(.KEY_MIN(KEY_MIN), .LOCK_ADDR(LOCK_ADDR)) fsm_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .zero_i    (zero),
      .mid_end_i (mid_end),
      .hi_end_i  (hi_end),
      .hi_long_i (hi_long),
      .locked_i  (fuse_q[CODE_W]),
      .wr_v_o    (wr_v),
      .wr_addr_o (wr_addr),
      .wr_long_o (wr_long)
   );

   spp_bit_store #(.CODE_W(CODE_W), .LOCK_ADDR(LOCK_ADDR)) store_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .zero_i    (zero),
      .wr_v_i    (wr_v),
      .wr_addr_i (wr_addr),
      .wr_long_i (wr_long),
      .code_o    (code_o),
      .fuse_o    (fuse_q),
      .blow_o    (blow_o)
   );

   assign lock_o = fuse_q[CODE_W];

endmodule

// File: rtl/spp_decoder_chk.sv
module spp_decoder_chk #(
   parameter int CODE_W = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [1:0]        lvl_i,
   input logic [CODE_W-1:0] code_o,
   input logic              lock_o,
   input logic [CODE_W:0]   blow_o,
   input logic [CODE_W:0]   fuse_bits
);
   // R4
   blow_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(blow_o));

   // R4
   blow_shows_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blow_o[CODE_W-1:0] != '0) |-> ((code_o & blow_o[CODE_W-1:0]) == blow_o[CODE_W-1:0]));

   // R5
   fuse_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      &(~$past(fuse_bits) | fuse_bits));

   // R5
   zero_clears_vol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i == 2'd0) |=> (code_o == fuse_bits[CODE_W-1:0]));

   // R8
   lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_o |=> lock_o);

   // R8
   locked_no_blow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_o |=> (blow_o == '0));

endmodule

bind spp_decoder spp_decoder_chk #(.CODE_W(CODE_W)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .lvl_i     (lvl_i),
   .code_o    (code_o),
   .lock_o    (lock_o),
   .blow_o    (blow_o),
   .fuse_bits (fuse_q)
);

// File: tb/spp_decoder_tb.sv
module spp_decoder_tb_top;
   localparam int LONG = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] lvl = 2'd0;
   logic [5:0] code;
   logic       lock;
   logic [6:0] blow;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spp_decoder dut_i (
      .clk_i(clk), .rst_ni(rst_n), .lvl_i(lvl),
      .code_o(code), .lock_o(lock), .blow_o(blow)
   );

   // behavioural reference model
   int m_prev, m_hrun, m_state, m_k, m_a, m_vol, m_fuse, m_lock, m_blow;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = 0; m_hrun = 0; m_state = 0; m_k = 0; m_a = 0;
         m_vol = 0; m_fuse = 0; m_lock = 0; m_blow = 0;
      end else begin
         int cur;
         bit hi_end, mid_end, long_p;
         cur = int'(lvl);
         hi_end  = (m_prev == 3) && (cur != 3);
         mid_end = (m_prev == 2) && (cur != 2);
         long_p  = (m_hrun >= LONG);
         m_blow = 0;
         if (cur == 0) begin
            m_vol = 0; m_state = 0; m_k = 0; m_a = 0;
         end else if (m_state == 0) begin
            if (hi_end && !long_p && m_lock == 0) begin m_state = 1; m_k = 0; end
         end else if (m_state == 1) begin
            if (mid_end) m_k++;
            else if (hi_end) begin
               if (m_k >= 7) begin m_state = 2; m_a = 0; end
               else m_state = 0;
            end
         end else begin
            if (mid_end) m_a++;
            else if (hi_end) begin
               if (m_a >= 1 && m_a <= 6) begin
                  m_vol |= 1 << (m_a - 1);
                  if (long_p) begin m_fuse |= 1 << (m_a - 1); m_blow = 1 << (m_a - 1); end
               end
               if (m_a == 65 && long_p) begin m_lock = 1; m_blow = 64; end
               m_state = 0;
            end
         end
         if (cur == 3) m_hrun = (m_prev == 3) ? ((m_hrun < LONG) ? m_hrun + 1 : LONG) : 1;
         else m_hrun = 0;
         m_prev = cur;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 model code", int'(code), m_vol | m_fuse);
         chk("R8 model lock", int'(lock), m_lock);
         chk("R4 model blow", int'(blow), m_blow);
      end
   end

   task automatic hold(int lv, int n);
      repeat (n) begin @(negedge clk); lvl = 2'(lv); end
   endtask
   task automatic pulse(int lv, int n);
      hold(lv, n); hold(1, 2);
   endtask
   task automatic enable(int nmid);
      pulse(3, 3);
      repeat (nmid) pulse(2, 2);
      pulse(3, 3);
   endtask
   task automatic seq(int addr, int hlen);
      enable(7);
      repeat (addr) pulse(2, 2);
      pulse(3, hlen);
   endtask
   task automatic clear_supply();
      hold(0, 2); hold(1, 2);
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      hold(0, 3);
      @(negedge clk); rst_n = 1'b1; lvl = 2'd1;
      @(negedge clk);
      chk("R1 reset code", int'(code), 0);
      chk("R1 reset lock", int'(lock), 0);
      chk("R1 reset blow", int'(blow), 0);

      seq(3, 3);
      chk("R3 addr3 short", int'(code), 4);
      seq(1, 3);
      chk("R6 accumulate 5", int'(code), 5);
      clear_supply();
      chk("R5 zero clears", int'(code), 0);

      enable(6); repeat (2) pulse(2, 2); pulse(3, 3);
      chk("R2 six mid refused", int'(code), 0);
      clear_supply();
      pulse(3, 20); repeat (7) pulse(2, 2); pulse(3, 3);
      pulse(2, 2); pulse(3, 3);
      chk("R2 long opener refused", int'(code), 0);
      clear_supply();

      seq(2, 3);
      chk("R3 addr2 short", int'(code), 2);
      repeat (4) pulse(2, 2); pulse(3, 3);
      chk("R9 no fresh enable", int'(code), 2);
      clear_supply();

      seq(0, 3);
      chk("R7 addr0", int'(code), 0);
      seq(7, 20);
      chk("R7 addr7 blow", int'(blow), 0);
      seq(40, 20);
      chk("R7 addr40 code", int'(code), 0);
      seq(65, 3);
      chk("R7 short lock addr", int'(lock), 0);

      seq(2, 20);
      chk("R4 long blow strobe", int'(blow), 2);
      chk("R4 long code", int'(code), 2);
      @(negedge clk);
      chk("R4 strobe one cycle", int'(blow), 0);
      clear_supply();
      chk("R5 fuse survives zero", int'(code), 2);

      seq(65, 20);
      chk("R8 lock set", int'(lock), 1);
      chk("R8 lock strobe", int'(blow), 64);
      seq(1, 20);
      chk("R8 locked ignores", int'(code), 2);
      clear_supply();
      chk("R8 lock kept", int'(lock), 1);

      hold(1, 3);
      finish_run();
   end
endmodule